// File: doc/BRIEF.md
# Atomic Byte-Addressed Memory

This block is a byte-addressed memory occupying one window of the address map. A single request channel carries an operation, an address, a size of 1, 2, 4 or 8 bytes, write data, a compare value and a locked flag. Every request gets one response after a fixed, configurable number of cycles, whatever the operation. The response carries the data and an ok/error status. A new request may be accepted every cycle, and responses come back in request order.

The memory supports five operations. A plain read returns the addressed bytes. A write can be made conditional, in which case an external reservation monitor decides whether it may go ahead. An invalidate/upgrade is acknowledged and leaves the data alone. An atomic swap stores the new value and returns the old one. A compare-and-swap stores the new value only when the old value matches the compare value. Swap and compare-and-swap share one read-modify-write path. A locked read also reports its address to the reservation monitor, so that the monitor can open a reservation. Data is little-endian. Read data is returned right-justified and zero-extended. Write data is taken from the low bytes of the write data input.

Top module: `atomic_mem`

## Requirements
- R1: With ZERO_INIT set, every location reads as zero before its first write.
- R2: A read returns the addressed bytes right-justified and zero-extended. Byte k of a word is at address offset k (little-endian). Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R3: A plain write (locked=0) changes exactly the bytes covered by its address and size. Its response data is zero.
- R4: A locked write changes memory only when store_permit is 1. Its response data is 1 on success and 0 on failure.
- R5: An invalidate (op code 2) returns ok with zero data and leaves memory unchanged.
- R6: A swap (op code 3) returns the old contents and stores the new value.
- R7: A compare-and-swap (op code 4) returns the old contents. It stores the new value only when the old contents equal the compare value. The 4-byte form compares only bits 31:0 of the compare value.
- R8: A compare-and-swap with size code 0 or 1 returns error status and writes nothing.
- R9: A request is an error and writes nothing when any byte falls outside [BASE_ADDR, BASE_ADDR+MEM_BYTES) or when the address is not a multiple of the size. An error response has zero data.
- R10: Op codes 5, 6 and 7 return error status and write nothing. Code 0 is read and code 1 is write.
- R11: Every response appears exactly LATENCY cycles after its request, one request per cycle is accepted, and back-to-back requests to one address see each other's effects in order.
- R12: A locked read without error raises resv_valid with resv_addr equal to its address in the cycle after the request. No other request raises resv_valid.
- R13: Synchronous reset clears rsp_valid and resv_valid and drops responses still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 invalidate, 3 swap, 4 compare-and-swap |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_locked | input | 1 | Locked read / conditional write |
| req_wdata | input | 64 | New data, right-justified |
| req_cmp | input | 64 | Compare value for compare-and-swap |
| store_permit | input | 1 | Reservation monitor verdict for a locked write |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 1 | 0 ok, 1 error |
| rsp_data | output | 64 | Old/read data or conditional-store result |
| resv_valid | output | 1 | Locked read seen; open a reservation |
| resv_addr | output | ADDR_W | Address of that locked read |

## Verification
A wrong byte-enable or lane shift corrupts neighbouring bytes without any sign on the response of the write itself. It shows only when a later full-word read comes back, LATENCY cycles after that read is issued. For that reason the vector table follows every write-like operation with a wide read-back. A wrong compare decision in compare-and-swap, or a wrong permit gate, is caught the same way. A write that the error path should have blocked shows as a changed word on the read that follows the error. A fault in the delay line shows as a response one cycle early or late, and the back-to-back pair catches a read that does not see the swap just before it.

// File: rtl/atomic_mem_pkg.sv
package atomic_mem_pkg;

  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_INVAL = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4
  } op_e;

  localparam logic ST_OK  = 1'b0;
  localparam logic ST_ERR = 1'b1;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'(1 << sz);
  endfunction

  function automatic logic [7:0] lane_enables(input logic [1:0] sz, input logic [2:0] lane);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << lane;
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/am_req_decode.sv
module am_req_decode
  import atomic_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  parameter int MEM_BYTES = 512,
  localparam int WORDS = MEM_BYTES / WORD_BYTES,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              err,
  output logic [IDX_W-1:0]  idx,
  output logic [2:0]        lane,
  output logic [7:0]        be
);

  logic [ADDR_W:0] off, last;
  logic below, in_rng, aligned, legal_op, cas_bad;

  always_comb begin
    off      = {1'b0, addr} - {1'b0, BASE_ADDR};
    last     = off + (ADDR_W+1)'(size_bytes(size));
    below    = addr < BASE_ADDR;
    in_rng   = !below && (last <= (ADDR_W+1)'(MEM_BYTES));
    aligned  = (addr[2:0] & 3'(size_bytes(size) - 4'd1)) == 3'd0;
    legal_op = op <= OP_CAS;
    cas_bad  = (op == OP_CAS) && (size < 2'd2);
    err      = !in_rng || !aligned || !legal_op || cas_bad;
    idx      = off[3 +: IDX_W];
    lane     = off[2:0];
    be       = lane_enables(size, off[2:0]);
  end

  AST_CAS_NARROW_ERR: assert property (@(posedge clk) disable iff (rst)
    valid && (op == OP_CAS) && !size[1] |-> err);  // R8

  AST_LANES_MATCH_SIZE: assert property (@(posedge clk) disable iff (rst)
    valid && !err |-> $countones(be) == int'(size_bytes(size)));  // R3

endmodule

// File: rtl/am_rmw_unit.sv
module am_rmw_unit
  import atomic_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              err,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [2:0]        lane,
  input  logic              locked,
  input  logic              permit,
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cmp,
  output logic              we,
  output logic [WORD_W-1:0] new_word,
  output logic [WORD_W-1:0] rsp_data
);

  logic [WORD_W-1:0] old_val;
  logic              match;

  always_comb begin
    old_val  = (old_word >> {lane, 3'b000}) & size_mask(size);
    new_word = wdata << {lane, 3'b000};
    match    = size[0] ? (old_val == cmp) : (old_val[31:0] == cmp[31:0]);
    we       = 1'b0;
    rsp_data = '0;
    if (valid && !err) begin
      case (op)
        OP_READ:  rsp_data = old_val;
        OP_WRITE: begin
          we       = !locked || permit;
          rsp_data = locked ? WORD_W'(permit) : '0;
        end
        OP_SWAP: begin
          we       = 1'b1;
          rsp_data = old_val;
        end
        OP_CAS: begin
          we       = match;
          rsp_data = old_val;
        end
        default: ;
      endcase
    end
  end

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> !we);  // R9

  AST_INVAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INVAL) |-> !we);  // R5

endmodule

// File: rtl/am_rsp_delay.sv
module am_rsp_delay #(
  parameter int LATENCY = 3,
  parameter int DW = 65,
  localparam int CW = $clog2(LATENCY + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);

  logic          vld [LATENCY];
  logic [DW-1:0] dat [LATENCY];

  always_ff @(posedge clk) begin
    vld[0] <= rst ? 1'b0 : in_v;
    dat[0] <= in_d;
  end

  for (genvar s = 1; s < LATENCY; s++) begin : g_stage
    always_ff @(posedge clk) begin
      vld[s] <= rst ? 1'b0 : vld[s-1];
      dat[s] <= dat[s-1];
    end
  end

  assign out_v = vld[LATENCY-1];
  assign out_d = out_v ? dat[LATENCY-1] : '0;

  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_v) - CW'(out_v);
  end

  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    out_v |-> inflight != '0);  // R11

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LATENCY));  // R11

endmodule

// File: rtl/atomic_mem.sv
module atomic_mem
  import atomic_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  parameter int MEM_BYTES = 512,
  parameter int LATENCY = 3,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_locked,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_cmp,
  input  logic              store_permit,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic [63:0]       rsp_data,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);

  localparam int WORDS = MEM_BYTES / WORD_BYTES;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORD_W-1:0] mem [WORDS];

  initial begin
    if (ZERO_INIT) begin
      for (int w = 0; w < WORDS; w++) mem[w] = '0;
    end
  end

  logic             err, we;
  logic [IDX_W-1:0] idx;
  logic [2:0]       lane;
  logic [7:0]       be;
  logic [WORD_W-1:0] old_word, new_word, rd_val;

  am_req_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES)) dec_i (
    .clk(clk), .rst(rst), .valid(req_valid), .op(req_op), .addr(req_addr),
    .size(req_size), .err(err), .idx(idx), .lane(lane), .be(be)
  );

  assign old_word = mem[idx];

  am_rmw_unit rmw_i (
    .clk(clk), .rst(rst), .valid(req_valid), .err(err), .op(req_op),
    .size(req_size), .lane(lane), .locked(req_locked), .permit(store_permit),
    .old_word(old_word), .wdata(req_wdata), .cmp(req_cmp),
    .we(we), .new_word(new_word), .rsp_data(rd_val)
  );

  always @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (be[b]) mem[idx][8*b +: 8] <= new_word[8*b +: 8];
      end
    end
  end

  logic [WORD_W:0] dly_out;

  am_rsp_delay #(.LATENCY(LATENCY), .DW(WORD_W + 1)) dly_i (
    .clk(clk), .rst(rst), .in_v(req_valid),
    .in_d({err ? ST_ERR : ST_OK, rd_val}),
    .out_v(rsp_valid), .out_d(dly_out)
  );

  assign rsp_status = dly_out[WORD_W];
  assign rsp_data   = dly_out[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else begin
      resv_valid <= req_valid && (req_op == OP_READ) && req_locked && !err;
      resv_addr  <= req_addr;
    end
  end

  AST_RESV_FROM_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
    resv_valid |-> $past(req_valid && req_locked && (req_op == OP_READ)));  // R12

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_status == ST_ERR) |-> rsp_data == '0);  // R9

endmodule

// File: tb/atomic_mem_tb_top.sv
module atomic_mem_tb_top;

  localparam int LAT = 3;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        locked;
    logic        permit;
    logic [63:0] wdata;
    logic [63:0] cmp;
    logic        est;
    logic [63:0] edata;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd1},                    // R1
    '{3'd1, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h1122334455667788, 64'h0, 1'b0, 64'h0, 8'd3},      // R3
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h1122334455667788, 8'd2},      // R2
    '{3'd0, 32'h1002, 2'd1, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h5566, 8'd2},                  // R2
    '{3'd0, 32'h1007, 2'd0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h11, 8'd2},                    // R2
    '{3'd1, 32'h1004, 2'd2, 1'b0, 1'b0, 64'hDEADBEEF, 64'h0, 1'b0, 64'h0, 8'd3},              // R3
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hDEADBEEF55667788, 8'd3},      // R3
    '{3'd1, 32'h1001, 2'd0, 1'b0, 1'b0, 64'hFFFFFFAB, 64'h0, 1'b0, 64'h0, 8'd3},              // R3
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hDEADBEEF5566AB88, 8'd3},      // R3
    '{3'd1, 32'h1000, 2'd3, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd4},                     // R4
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hDEADBEEF5566AB88, 8'd4},      // R4
    '{3'd1, 32'h1008, 2'd3, 1'b1, 1'b1, 64'hCAFE, 64'h0, 1'b0, 64'h1, 8'd4},                  // R4
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hCAFE, 8'd4},                  // R4
    '{3'd2, 32'h1008, 2'd3, 1'b0, 1'b0, 64'hFFFF, 64'h0, 1'b0, 64'h0, 8'd5},                  // R5
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hCAFE, 8'd5},                  // R5
    '{3'd3, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h1234, 64'h0, 1'b0, 64'hCAFE, 8'd6},               // R6
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h1234, 8'd6},                  // R6
    '{3'd4, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h5678, 64'h1234, 1'b0, 64'h1234, 8'd7},            // R7
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h5678, 8'd7},                  // R7
    '{3'd4, 32'h1008, 2'd3, 1'b0, 1'b0, 64'hAAAA, 64'h9999, 1'b0, 64'h5678, 8'd7},            // R7
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h5678, 8'd7},                  // R7
    '{3'd4, 32'h100C, 2'd2, 1'b0, 1'b0, 64'h77, 64'hFFFFFFFF00000000, 1'b0, 64'h0, 8'd7},     // R7
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0000007700005678, 8'd7},      // R7
    '{3'd4, 32'h1008, 2'd1, 1'b0, 1'b0, 64'h1, 64'h5678, 1'b1, 64'h0, 8'd8},                  // R8
    '{3'd0, 32'h1008, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0000007700005678, 8'd8},      // R8
    '{3'd3, 32'h1010, 2'd1, 1'b0, 1'b0, 64'hBEEF, 64'h0, 1'b0, 64'h0, 8'd6},                  // R6
    '{3'd0, 32'h1010, 2'd0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hEF, 8'd6},                    // R6
    '{3'd1, 32'h11F8, 2'd3, 1'b0, 1'b0, 64'hA5, 64'h0, 1'b0, 64'h0, 8'd9},                    // R9
    '{3'd0, 32'h11F8, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hA5, 8'd9},                    // R9
    '{3'd0, 32'h11FC, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 64'h0, 8'd9},                     // R9
    '{3'd0, 32'h1200, 2'd0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 64'h0, 8'd9},                     // R9
    '{3'd1, 32'h0FFF, 2'd0, 1'b0, 1'b0, 64'h5A, 64'h0, 1'b1, 64'h0, 8'd9},                    // R9
    '{3'd1, 32'h1200, 2'd3, 1'b0, 1'b0, 64'h5A, 64'h0, 1'b1, 64'h0, 8'd9},                    // R9
    '{3'd7, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h5A, 64'h0, 1'b1, 64'h0, 8'd10},                   // R10
    '{3'd0, 32'h1000, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'hDEADBEEF5566AB88, 8'd10}      // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_locked = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_cmp = '0;
  logic        store_permit = 1'b0;
  logic        rsp_valid, rsp_status, resv_valid;
  logic [63:0] rsp_data;
  logic [31:0] resv_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  atomic_mem #(.ADDR_W(32), .BASE_ADDR(32'h1000), .MEM_BYTES(512), .LATENCY(LAT), .ZERO_INIT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_locked(req_locked), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .store_permit(store_permit), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid    = 1'b1;
    req_op       = v.op;
    req_addr     = v.addr;
    req_size     = v.size;
    req_locked   = v.locked;
    store_permit = v.permit;
    req_wdata    = v.wdata;
    req_cmp      = v.cmp;
  endtask

  task automatic idle();
    req_valid  = 1'b0;
    req_locked = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R13 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check("R13 resv_valid after reset", 64'(resv_valid), 64'h0);

    // Vector table: one request, then sample its response LAT edges later.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      idle();
      check($sformatf("R11 vec%0d early rsp", i), 64'(rsp_valid), 64'(LAT == 1));
      repeat (LAT - 1) @(negedge clk);
      check($sformatf("R11 vec%0d rsp_valid", i), 64'(rsp_valid), 64'h1);
      check($sformatf("R%0d vec%0d status", VECS[i].rq, i), 64'(rsp_status), 64'(VECS[i].est));
      check($sformatf("R%0d vec%0d data", VECS[i].rq, i), rsp_data, VECS[i].edata);
      @(negedge clk);
    end

    // R12: locked read reports its address one cycle later.
    drive('{3'd0, 32'h1010, 2'd0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd12});
    @(negedge clk);
    idle();
    check("R12 resv_valid on locked read", 64'(resv_valid), 64'h1);
    check("R12 resv_addr", 64'(resv_addr), 64'h1010);
    // R12: unlocked read and locked swap do not.
    drive('{3'd0, 32'h1010, 2'd0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd12});
    @(negedge clk);
    check("R12 no resv on plain read", 64'(resv_valid), 64'h0);
    drive('{3'd3, 32'h1020, 2'd3, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd12});
    @(negedge clk);
    idle();
    check("R12 no resv on locked swap", 64'(resv_valid), 64'h0);
    repeat (LAT + 1) @(negedge clk);

    // R11: back-to-back swap then read of the same word.
    drive('{3'd3, 32'h1018, 2'd3, 1'b0, 1'b0, 64'h42, 64'h0, 1'b0, 64'h0, 8'd11});
    @(negedge clk);
    drive('{3'd0, 32'h1018, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd11});
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R11 b2b first valid", 64'(rsp_valid), 64'h1);
    check("R11 b2b swap old", rsp_data, 64'h0);
    @(negedge clk);
    check("R11 b2b second valid", 64'(rsp_valid), 64'h1);
    check("R11 b2b read sees swap", rsp_data, 64'h42);
    @(negedge clk);
    check("R11 pipeline empty", 64'(rsp_valid), 64'h0);

    // R13: reset while a response is in flight drops it.
    drive('{3'd0, 32'h1018, 2'd3, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd13});
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (LAT) begin
      check("R13 in-flight dropped", 64'(rsp_valid), 64'h0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule